// File: doc/BRIEF.md
# Dual-Mode Processor Bus Slave

This block connects a local processor to a small on-chip register bank. A static strap input picks one of two bus styles. In the first style the host has separate active-low read and write strobes. In the second style the host has one active-low data strobe plus a direction line. Both styles share an address input that is captured on the falling edge of a latch strobe, and an active-low chip select. The data bus is split into input, output and output-enable, and the block answers every access with an active-low ready handshake.

Every host strobe is brought into the system clock through a two-stage synchroniser, and one state machine serves both styles. On the inside the block drives a generic register port: an address, write data, a one-cycle write pulse and a one-cycle read pulse, with read data returned in the same cycle. A separate open-drain interrupt request is modelled as a pull-low enable. It is active whenever any pending source is also enabled.

Top module: `upif_bridge`

## Requirements
- R1: `mode_moto` = 1 selects the data-strobe style, where `rd_ds_n` is the data strobe and `wr_rw_n` is the direction line (1 = read, 0 = write). `mode_moto` = 0 selects the split-strobe style, where `rd_ds_n` is the read strobe and `wr_rw_n` is the write strobe. In the data-strobe style, a low direction line with the data strobe high starts no cycle.
- R2: The 9-bit `addr_in` is captured on the falling edge of `ale`, three clocks after that edge, and the captured value addresses all 512 locations through `reg_addr`.
- R3: While `cs_n` is high, no strobe starts a cycle. `rdy_n` stays high, `data_oe` stays 0, and no `reg_we` or `reg_re` pulse occurs.
- R4: A read drives `data_oe` = 1 and `data_out` = the addressed register's contents while `rdy_n` is low. `data_oe` returns to 0 three clocks after the strobe is released.
- R5: A write samples `data_in` when ready asserts. It commits that value with exactly one `reg_we` pulse after the strobe rises.
- R6: In the data-strobe style a cycle starts when `cs_n` and `rd_ds_n` are both low. The direction is taken from `wr_rw_n` at that moment, and the write commits when the data strobe rises.
- R7: `rdy_n` goes low five clocks after a strobe edge driven between clock edges: two synchroniser stages, one detection clock and `ACK_DLY` = 2 clocks. It goes high again three clocks after the strobe is released.
- R8: `data_oe` is never 1 during a write cycle.
- R9: `irq_pull_low` is 1 exactly when some bit is set in both `irq_pend` and `irq_en`.
- R10: In the split-strobe style, read and write strobes that are low together start no cycle.
- R11: Each read cycle produces exactly one single-clock `reg_re` pulse, and write cycles produce none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_moto | input | 1 | Bus style strap: 1 data-strobe style, 0 split-strobe style |
| ale | input | 1 | Address latch strobe, captures on falling edge |
| addr_in | input | 9 | Host address |
| cs_n | input | 1 | Active-low chip select |
| rd_ds_n | input | 1 | Read strobe or data strobe, active low |
| wr_rw_n | input | 1 | Write strobe (active low) or direction line (1 read) |
| data_in | input | 8 | Host data toward the block |
| data_out | output | 8 | Read data toward the host, 0 when not driven |
| data_oe | output | 1 | Data bus output enable |
| rdy_n | output | 1 | Active-low ready/acknowledge |
| irq_pend | input | 8 | Pending interrupt sources |
| irq_en | input | 8 | Interrupt source enables |
| irq_pull_low | output | 1 | 1 = pull the open-drain interrupt line low |
| reg_addr | output | 9 | Register bank address |
| reg_wdata | output | 8 | Register bank write data |
| reg_we | output | 1 | One-cycle register write pulse |
| reg_re | output | 1 | One-cycle register read pulse |
| reg_rdata | input | 8 | Register bank read data, same cycle |

## Verification
The bench drives every host strobe on the falling clock edge and samples on later falling edges. Each result is therefore due a whole number of rising edges after its stimulus. The address is captured after three rising edges. Ready and read data appear after five, and ready and the output enable release after three. The bench checks that `rdy_n` is still high after four edges and low after five, and still low two edges after release and high after three. This pins each transition to its exact edge rather than checking it eventually. Register writes are counted per access by a monitor, and the full 512-location sweep in both styles compares read data against a model the bench fills itself.

// File: rtl/upif_pkg.sv
package upif_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_ACK  = 2'd2
  } upif_state_e;

  // Returns {go, is_read} from synchronised strobe levels.
  function automatic logic [1:0] req_decode(input logic moto, input logic cs_n,
                                            input logic a_n, input logic b);
    logic go;
    logic rd;
    if (moto) begin
      go = !cs_n && !a_n;
      rd = b;
    end else begin
      go = !cs_n && (a_n ^ b);
      rd = !a_n;
    end
    return {go, rd};
  endfunction

  // True while the strobe that opened the cycle is still held.
  function automatic logic strobe_held(input logic moto, input logic cs_n,
                                       input logic a_n, input logic b,
                                       input logic is_rd);
    if (moto) return !cs_n && !a_n;
    return !cs_n && (is_rd ? !a_n : !b);
  endfunction

  function automatic logic any_irq(input logic [7:0] pend, input logic [7:0] en);
    return |(pend & en);
  endfunction

endpackage

// File: rtl/upif_sync.sv
module upif_sync #(
  parameter int W = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stage1;
  logic [W-1:0] stage2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= RST_VAL;
      stage2 <= RST_VAL;
    end else begin
      stage1 <= async_in;
      stage2 <= stage1;
    end
  end

  assign sync_out = stage2;
endmodule

// File: rtl/upif_addr_latch.sv
module upif_addr_latch #(
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ale_s,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] addr_q,
  output logic          latch_ev
);
  logic ale_prev;

  assign latch_ev = ale_prev && !ale_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ale_prev <= 1'b0;
      addr_q   <= '0;
    end else begin
      ale_prev <= ale_s;
      if (latch_ev) addr_q <= addr_in;
    end
  end
endmodule

// File: rtl/upif_fsm.sv
module upif_fsm
  import upif_pkg::*;
#(
  parameter int DW      = 8,
  parameter int ACK_DLY = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_moto,
  input  logic          cs_sn,
  input  logic          stra_sn,
  input  logic          strb_s,
  input  logic [DW-1:0] data_in,
  input  logic [DW-1:0] reg_rdata,
  output logic [DW-1:0] data_out,
  output logic          data_oe,
  output logic          rdy_n,
  output logic [DW-1:0] reg_wdata,
  output logic          reg_we,
  output logic          reg_re,
  output logic          start_ev,
  output logic          release_ev
);
  localparam int CW = $clog2(ACK_DLY + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(ACK_DLY - 1);

  upif_state_e   st;
  logic [CW-1:0] cnt;
  logic          is_rd_q;
  logic [DW-1:0] rd_q;
  logic [DW-1:0] wd_q;
  logic [1:0]    req;
  logic          hold;

  assign req        = req_decode(mode_moto, cs_sn, stra_sn, strb_s);
  assign hold       = strobe_held(mode_moto, cs_sn, stra_sn, strb_s, is_rd_q);
  assign start_ev   = (st == ST_IDLE) && req[1];
  assign release_ev = (st == ST_ACK) && !hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      is_rd_q <= 1'b0;
      rd_q    <= '0;
      wd_q    <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (req[1]) begin
            st      <= ST_WAIT;
            cnt     <= '0;
            is_rd_q <= req[0];
          end
        end
        ST_WAIT: begin
          if (cnt == '0 && is_rd_q) rd_q <= reg_rdata;
          if (cnt == CNT_LAST) begin
            st   <= ST_ACK;
            wd_q <= data_in;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_ACK: begin
          if (!hold) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign reg_re    = (st == ST_WAIT) && (cnt == '0) && is_rd_q;
  assign reg_we    = release_ev && !is_rd_q;
  assign reg_wdata = wd_q;
  assign data_oe   = (st == ST_ACK) && is_rd_q;
  assign data_out  = data_oe ? rd_q : '0;
  assign rdy_n     = !(st == ST_ACK);
endmodule

// File: rtl/upif_bridge.sv
module upif_bridge
  import upif_pkg::*;
#(
  parameter int AW      = 9,
  parameter int DW      = 8,
  parameter int NIRQ    = 8,
  parameter int ACK_DLY = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mode_moto,
  input  logic            ale,
  input  logic [AW-1:0]   addr_in,
  input  logic            cs_n,
  input  logic            rd_ds_n,
  input  logic            wr_rw_n,
  input  logic [DW-1:0]   data_in,
  output logic [DW-1:0]   data_out,
  output logic            data_oe,
  output logic            rdy_n,
  input  logic [NIRQ-1:0] irq_pend,
  input  logic [NIRQ-1:0] irq_en,
  output logic            irq_pull_low,
  output logic [AW-1:0]   reg_addr,
  output logic [DW-1:0]   reg_wdata,
  output logic            reg_we,
  output logic            reg_re,
  input  logic [DW-1:0]   reg_rdata
);
  // Synchronised strobe vector: {ale, cs_n, rd_ds_n, wr_rw_n}
  localparam int NSTB = 4;
  localparam logic [NSTB-1:0] STB_RST = 4'b0111;

  logic [NSTB-1:0] stb_raw;
  logic [NSTB-1:0] stb_s;
  logic            latch_ev;
  logic            start_ev;
  logic            release_ev;
  logic [7:0]      pend8;
  logic [7:0]      en8;

  assign stb_raw = {ale, cs_n, rd_ds_n, wr_rw_n};

  upif_sync #(.W(NSTB), .RST_VAL(STB_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(stb_raw), .sync_out(stb_s)
  );

  upif_addr_latch #(.AW(AW)) u_alat (
    .clk(clk), .rst_n(rst_n), .ale_s(stb_s[3]), .addr_in(addr_in),
    .addr_q(reg_addr), .latch_ev(latch_ev)
  );

  upif_fsm #(.DW(DW), .ACK_DLY(ACK_DLY)) u_fsm (
    .clk(clk), .rst_n(rst_n), .mode_moto(mode_moto),
    .cs_sn(stb_s[2]), .stra_sn(stb_s[1]), .strb_s(stb_s[0]),
    .data_in(data_in), .reg_rdata(reg_rdata),
    .data_out(data_out), .data_oe(data_oe), .rdy_n(rdy_n),
    .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_re(reg_re),
    .start_ev(start_ev), .release_ev(release_ev)
  );

  // Interrupt sources folded into 8-bit slices for the shared helper.
  generate
    if (NIRQ >= 8) begin : g_wide
      logic [NIRQ-1:0] masked;
      assign masked = irq_pend & irq_en;
      assign pend8  = {7'd0, |masked};
      assign en8    = 8'd1;
    end else begin : g_narrow
      assign pend8 = 8'(irq_pend);
      assign en8   = 8'(irq_en);
    end
  endgenerate

  assign irq_pull_low = any_irq(pend8, en8);
endmodule

// File: rtl/upif_chk.sv
module upif_chk #(
  parameter int ACK_DLY = 2
) (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic rdy_n,
  input logic data_oe,
  input logic reg_we,
  input logic reg_re,
  input logic start_ev,
  input logic release_ev
);
  logic [7:0] since;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since <= 8'hFF;
    else if (start_ev) since <= 8'd0;
    else if (since != 8'hFF) since <= since + 8'd1;
  end

  a_r3_cs_gates_start: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |-> !$past(cs_n, 2));

  a_r4_oe_within_ack: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> !rdy_n);

  a_r7_ack_delay: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy_n) |-> (since == 8'(ACK_DLY)));

  a_r7_release_ready: assert property (@(posedge clk) disable iff (!rst_n)
    release_ev |=> rdy_n);

  a_r8_no_drive_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> !data_oe);

  a_r11_read_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    reg_re |=> !reg_re);
endmodule

bind upif_bridge upif_chk #(.ACK_DLY(ACK_DLY)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rdy_n(rdy_n), .data_oe(data_oe),
  .reg_we(reg_we), .reg_re(reg_re), .start_ev(start_ev), .release_ev(release_ev)
);

// File: tb/sim_upif_bridge.sv
module sim_upif_bridge;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_moto = 1'b0;
  logic       ale = 1'b0;
  logic [8:0] addr_in = '0;
  logic       cs_n = 1'b1;
  logic       rd_ds_n = 1'b1;
  logic       wr_rw_n = 1'b1;
  logic [7:0] data_in = '0;
  logic [7:0] data_out;
  logic       data_oe;
  logic       rdy_n;
  logic [7:0] irq_pend = '0;
  logic [7:0] irq_en = '0;
  logic       irq_pull_low;
  logic [8:0] reg_addr;
  logic [7:0] reg_wdata;
  logic       reg_we;
  logic       reg_re;
  logic [7:0] reg_rdata;

  int checks = 0;
  int fails  = 0;
  int we_cnt = 0;
  int re_cnt = 0;
  logic [7:0] bank  [512];
  logic [7:0] model [512];

  always #10 clk = ~clk;

  upif_bridge u0 (
    .clk(clk), .rst_n(rst_n), .mode_moto(mode_moto), .ale(ale), .addr_in(addr_in),
    .cs_n(cs_n), .rd_ds_n(rd_ds_n), .wr_rw_n(wr_rw_n), .data_in(data_in),
    .data_out(data_out), .data_oe(data_oe), .rdy_n(rdy_n), .irq_pend(irq_pend),
    .irq_en(irq_en), .irq_pull_low(irq_pull_low), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata)
  );

  // Register bank owned by the bench.
  assign reg_rdata = bank[reg_addr];
  always @(posedge clk) begin
    if (reg_we) bank[reg_addr] <= reg_wdata;
    if (reg_we) we_cnt <= we_cnt + 1;
    if (reg_re) re_cnt <= re_cnt + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic latch_addr(input logic [8:0] a);
    @(negedge clk); addr_in = a; ale = 1'b1;
    @(negedge clk); ale = 1'b0;
    repeat (4) @(negedge clk);
    chk("R2 latched address", 32'(reg_addr), 32'(a));
  endtask

  function automatic logic [7:0] pattern(input int a, input int m);
    return 8'((a * 7 + m * 90) ^ (a >> 1));
  endfunction

  task automatic access(input bit moto, input bit rd, input logic [8:0] a,
                        input logic [7:0] d);
    int we0;
    int re0;
    latch_addr(a);
    we0 = we_cnt; re0 = re_cnt;
    cs_n = 1'b0; data_in = d;
    if (moto) begin wr_rw_n = rd; rd_ds_n = 1'b0; end
    else if (rd) rd_ds_n = 1'b0;
    else wr_rw_n = 1'b0;
    repeat (4) @(negedge clk);
    chk("R7 ready still high after 4 clocks", 32'(rdy_n), 32'd1);
    @(negedge clk);
    chk("R7 ready low after 5 clocks", 32'(rdy_n), 32'd0);
    if (rd) begin
      chk(moto ? "R6 read enable" : "R4 read enable", 32'(data_oe), 32'd1);
      chk(moto ? "R6 read data" : "R4 read data", 32'(data_out), 32'(model[a]));
    end else begin
      chk("R8 no drive during write", 32'(data_oe), 32'd0);
    end
    repeat (2) @(negedge clk);
    cs_n = 1'b1; rd_ds_n = 1'b1; wr_rw_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R7 ready held 2 clocks after release", 32'(rdy_n), 32'd0);
    @(negedge clk);
    chk("R7 ready high 3 clocks after release", 32'(rdy_n), 32'd1);
    chk("R4 enable off after release", 32'(data_oe), 32'd0);
    data_in = 8'hEE;
    @(negedge clk);
    chk(moto ? "R6 write pulse count" : "R5 write pulse count", 32'(we_cnt - we0), rd ? 32'd0 : 32'd1);
    chk("R11 read pulse count", 32'(re_cnt - re0), rd ? 32'd1 : 32'd0);
    if (!rd) model[a] = d;
  endtask

  task automatic no_cycle(input string req, input bit moto, input logic c,
                          input logic a_n, input logic b);
    int we0;
    int re0;
    mode_moto = moto;
    we0 = we_cnt; re0 = re_cnt;
    @(negedge clk); cs_n = c; rd_ds_n = a_n; wr_rw_n = b; data_in = 8'h3C;
    repeat (8) @(negedge clk);
    chk(req, 32'(rdy_n), 32'd1);
    chk(req, 32'(data_oe), 32'd0);
    chk(req, 32'(we_cnt - we0 + re_cnt - re0), 32'd0);
    cs_n = 1'b1; rd_ds_n = 1'b1; wr_rw_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7 reset ready", 32'(rdy_n), 32'd1);
    chk("R4 reset enable", 32'(data_oe), 32'd0);
    chk("R9 reset irq", 32'(irq_pull_low), 32'd0);

    // R1/R5/R4: split-strobe style full sweep
    mode_moto = 1'b0;
    for (int a = 0; a < 512; a++) access(1'b0, 1'b0, 9'(a), pattern(a, 0));
    for (int a = 0; a < 512; a++) access(1'b0, 1'b1, 9'(a), 8'h00);

    // R1/R6: data-strobe style full sweep
    mode_moto = 1'b1;
    for (int a = 0; a < 512; a++) access(1'b1, 1'b0, 9'(a), pattern(a, 1));
    for (int a = 0; a < 512; a++) access(1'b1, 1'b1, 9'(a), 8'h00);

    // R3: chip select high blocks both styles
    no_cycle("R3 read with cs high", 1'b0, 1'b1, 1'b0, 1'b1);
    no_cycle("R3 write with cs high", 1'b0, 1'b1, 1'b1, 1'b0);
    no_cycle("R3 strobe with cs high", 1'b1, 1'b1, 1'b0, 1'b0);
    // R10: both split strobes together
    no_cycle("R10 both strobes low", 1'b0, 1'b0, 1'b0, 1'b0);
    // R1: direction line alone starts nothing in data-strobe style
    no_cycle("R1 direction low without strobe", 1'b1, 1'b0, 1'b1, 1'b0);

    // Confirm blocked cycles left the bank untouched
    mode_moto = 1'b0;
    access(1'b0, 1'b1, 9'd0, 8'h00);
    access(1'b0, 1'b1, 9'd511, 8'h00);

    // R9: interrupt pull-low against many pending/enable pairs
    for (int p = 0; p < 256; p++) begin
      logic [7:0] e;
      bit any;
      e = 8'(p * 37 + 11);
      any = 1'b0;
      for (int i = 0; i < 8; i++) if (p[i] && e[i]) any = 1'b1;
      @(negedge clk); irq_pend = 8'(p); irq_en = e;
      #1 chk("R9 irq pull low", 32'(irq_pull_low), 32'(any));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule